// File: doc/BRIEF.md
# Track Record Emitter with Layer Occupancy Mask

This block turns fitted tracks into a stream of 64-bit records for a downstream tracking processor. A track descriptor arrives first on its own valid/ready channel: region indices, four bin indices, fixed-point fitted parameters and an end-of-event flag. The track's hits then arrive one per transfer on a second channel. Each hit carries a layer number, a real/fake flag, a position field, an auxiliary field and an end-of-track marker. Every hit, real or fake, sets one bit in a layer occupancy mask. Only the real hits are kept in a small buffer for emission.

Once the final hit of a track has been taken, the block emits a three-word track header, then two words for each buffered real hit, in arrival order. The mask therefore reaches the first header word complete. The first track of an event is preceded by a three-word event header. The track marked as ending the event is followed by a three-word event footer, which carries the number of words already sent in that event. The output is a single 64-bit valid/ready stream with a marker on the final word of each event.

Top module: `track_record_emitter`

## Requirements
- R1: Before the track header of the first track of an event, three event header words are emitted:
  - word 1 has 0xB5 in bits [63:56] and the event sequence number in bits [31:0], with all other bits zero;
  - word 2 has RUN_TAG in bits [63:32] and zero in bits [31:0];
  - word 3 is zero.
- R2: Track header word 1 has the following fields:
  - 0xEE in [63:56];
  - zero type in [55:54];
  - eta region in [53:48];
  - phi region in [47:42];
  - bin 0 in [41:34];
  - bin 1 in [33:26];
  - zero second-stage bit in [25];
  - the layer mask, zero-extended, in [24:0].
- R3: The layer mask is the OR, over every hit of the track whether real or fake, of 2 shifted left by the hit's layer number, so bit 0 is always zero. The mask starts from zero for each track.
- R4: Track header word 2 holds bin 2 in [63:56], d0 in [55:40] and z0 in [39:24], with zero below. Word 3 holds q/pt in [63:48], phi in [47:32], eta in [31:16] and bin 3 in [15:8], with zero elsewhere.
- R5: Only real hits are emitted after the track header, in the order they arrived, each as two words:
  - word 1 has the last flag in [63], a zero last-of-slice flag in [62], the layer in [61:56] and the position in [47:0];
  - word 2 has the auxiliary field in [31:0].
- R6: The last flag is set on the final real hit of a track and on no other hit. A track with no real hits emits only its three header words.
- R7: After the track whose end-of-event flag is set, three footer words are emitted:
  - word 1 has 0xD7 in [63:56] and zero elsewhere;
  - word 2 is zero;
  - word 3 holds, in [63:32], the count of words already emitted in the event, and CHECK_TAG in [31:0].
  - `out_last` is high on footer word 3 only.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values. Every word is delivered exactly once, in order.
- R9: A track is accepted only while the block is idle. Hits are accepted only between the acceptance of a track and its end-of-track hit. No input is accepted while output words are pending. At most MAX_HITS real hits are allowed per track.
- R10: The event sequence number is zero after reset and increases by one after each footer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trk_valid | input | 1 | Track descriptor valid |
| trk_ready | output | 1 | Track descriptor accepted when high with valid |
| trk_eta_rgn | input | 6 | Eta region index |
| trk_phi_rgn | input | 6 | Phi region index |
| trk_bin0 | input | 8 | Bin index 0 |
| trk_bin1 | input | 8 | Bin index 1 |
| trk_bin2 | input | 8 | Bin index 2 |
| trk_bin3 | input | 8 | Bin index 3 |
| trk_d0 | input | 16 | Fixed-point d0 |
| trk_z0 | input | 16 | Fixed-point z0 |
| trk_qpt | input | 16 | Fixed-point q/pt |
| trk_phi | input | 16 | Fixed-point phi |
| trk_eta | input | 16 | Fixed-point eta |
| trk_evt_end | input | 1 | Track is the last of its event |
| hit_valid | input | 1 | Hit valid |
| hit_ready | output | 1 | Hit accepted when high with valid |
| hit_layer | input | LAYER_W | Layer number of the hit |
| hit_real | input | 1 | Hit is real (1) or fake (0) |
| hit_pos | input | POS_W | Packed position field |
| hit_aux | input | AUX_W | Auxiliary field |
| hit_end | input | 1 | Hit is the last of its track |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 64 | Output word |
| out_last | output | 1 | Final word of the event |

## Verification
The bench goes through every real/fake pattern for tracks of one to four hits, including tracks whose hits are all fake and layers that reach the top mask bit. A design that dropped fake hits before building the mask, or shifted by the layer alone, would show a wrong mask in header word 1. A design that set the last flag from the input end marker would flag the wrong hit when the final input hit is fake. Events of several tracks under random output stalls expose a footer word count that is off by one, a header repeated for a later track of the same event, and data that changes during a stall.

// File: rtl/emit_pkg.sv
package emit_pkg;

   localparam int REG_W  = 6;
   localparam int BIN_W  = 8;
   localparam int PAR_W  = 16;
   localparam int MASK_FIELD_W = 25;
   localparam int LYR_FIELD_W  = 6;
   localparam int POS_FIELD_W  = 48;
   localparam int AUX_FIELD_W  = 32;

   localparam logic [7:0] EVT_HDR_TAG = 8'hB5;
   localparam logic [7:0] TRK_HDR_TAG = 8'hEE;
   localparam logic [7:0] EVT_FTR_TAG = 8'hD7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_EHDR,
      ST_THDR,
      ST_HIT,
      ST_FTR
   } seq_state_t;

   typedef struct packed {
      logic             evt_end;
      logic [REG_W-1:0] eta_rgn;
      logic [REG_W-1:0] phi_rgn;
      logic [BIN_W-1:0] bin0;
      logic [BIN_W-1:0] bin1;
      logic [BIN_W-1:0] bin2;
      logic [BIN_W-1:0] bin3;
      logic [PAR_W-1:0] d0;
      logic [PAR_W-1:0] z0;
      logic [PAR_W-1:0] qpt;
      logic [PAR_W-1:0] phi;
      logic [PAR_W-1:0] eta;
   } trk_desc_t;

   function automatic logic [63:0] pack_trk_w1(trk_desc_t d, logic [MASK_FIELD_W-1:0] m);
      return {TRK_HDR_TAG, 2'b00, d.eta_rgn, d.phi_rgn, d.bin0, d.bin1, 1'b0, m};
   endfunction

   function automatic logic [63:0] pack_trk_w2(trk_desc_t d);
      return {d.bin2, d.d0, d.z0, 24'h0};
   endfunction

   function automatic logic [63:0] pack_trk_w3(trk_desc_t d);
      return {d.qpt, d.phi, d.eta, d.bin3, 8'h00};
   endfunction

   function automatic logic [63:0] pack_hit_w1(logic last, logic [LYR_FIELD_W-1:0] lyr,
                                               logic [POS_FIELD_W-1:0] pos);
      return {last, 1'b0, lyr, 8'h00, pos};
   endfunction

   function automatic logic [63:0] pack_hit_w2(logic [AUX_FIELD_W-1:0] aux);
      return {32'h0, aux};
   endfunction

endpackage

// File: rtl/layer_mask_acc.sv
module layer_mask_acc #(
   parameter int LAYER_W = 4,
   localparam int LAYER_N = 1 << LAYER_W,
   localparam int MASK_W  = LAYER_N + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               add,
   input  logic [LAYER_W-1:0] layer,
   output logic [MASK_W-1:0]  mask
);

   assign mask[0] = 1'b0;

   for (genvar b = 1; b < MASK_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            bit_q <= 1'b0;
         end else if (add && (layer == LAYER_W'(b - 1))) begin
            bit_q <= 1'b1;
         end
      end
      assign mask[b] = bit_q;
   end

   // R3
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask == '0));
   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add && !clr) |=> mask[32'($past(layer)) + 1]);
   // R3
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!add && !clr) |=> $stable(mask));

endmodule

// File: rtl/hit_buffer.sv
module hit_buffer #(
   parameter int DEPTH = 8,
   parameter int ENT_W = 84,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ENT_W-1:0] rd_data
);

   logic [ENT_W-1:0] ent [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(e))) begin
            ent[e] <= wr_data;
         end
      end
   end

   assign rd_data = ent[rd_idx];

endmodule

// File: rtl/rec_sequencer.sv
module rec_sequencer
   import emit_pkg::*;
#(
   parameter int          LAYER_W   = 4,
   parameter int          MAX_HITS  = 8,
   parameter int          POS_W     = 48,
   parameter int          AUX_W     = 32,
   parameter logic [31:0] RUN_TAG   = 32'h0,
   parameter logic [31:0] CHECK_TAG = 32'h0,
   localparam int MASK_W = (1 << LAYER_W) + 1,
   localparam int CNT_W  = $clog2(MAX_HITS + 1),
   localparam int RD_W   = $clog2(MAX_HITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trk_valid,
   output logic               trk_ready,
   input  trk_desc_t          trk_in,
   input  logic               hit_valid,
   output logic               hit_ready,
   input  logic               hit_real,
   input  logic               hit_end,
   output logic               mask_clr,
   output logic               mask_add,
   input  logic [MASK_W-1:0]  mask,
   output logic               buf_wr_en,
   output logic [RD_W-1:0]    buf_wr_idx,
   output logic [RD_W-1:0]    buf_rd_idx,
   input  logic [LAYER_W-1:0] rd_layer,
   input  logic [POS_W-1:0]   rd_pos,
   input  logic [AUX_W-1:0]   rd_aux,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [63:0]        out_data,
   output logic               out_last
);

   seq_state_t       state;
   trk_desc_t        desc;
   logic             in_evt;
   logic [1:0]       sub;
   logic [CNT_W-1:0] hit_cnt;
   logic [CNT_W-1:0] hit_idx;
   logic [31:0]      evt_seq;
   logic [31:0]      word_cnt;

   logic trk_fire, hit_fire, out_fire, last_hit, sub_end;
   seq_state_t after_trk;

   assign trk_ready = (state == ST_IDLE);
   assign hit_ready = (state == ST_COLLECT);
   assign out_valid = (state == ST_EHDR) || (state == ST_THDR) ||
                      (state == ST_HIT)  || (state == ST_FTR);
   assign trk_fire  = trk_valid && trk_ready;
   assign hit_fire  = hit_valid && hit_ready;
   assign out_fire  = out_valid && out_ready;

   assign mask_clr   = trk_fire;
   assign mask_add   = hit_fire;
   assign buf_wr_en  = hit_fire && hit_real;
   assign buf_wr_idx = RD_W'(hit_cnt);
   assign buf_rd_idx = RD_W'(hit_idx);

   assign last_hit  = (hit_idx == hit_cnt - CNT_W'(1));
   assign sub_end   = (sub == 2'd2);
   assign after_trk = desc.evt_end ? ST_FTR : ST_IDLE;
   assign out_last  = (state == ST_FTR) && sub_end;

   always_comb begin
      out_data = '0;
      unique case (state)
         ST_EHDR: begin
            case (sub)
               2'd0:    out_data = {EVT_HDR_TAG, 24'h0, evt_seq};
               2'd1:    out_data = {RUN_TAG, 32'h0};
               default: out_data = '0;
            endcase
         end
         ST_THDR: begin
            case (sub)
               2'd0:    out_data = pack_trk_w1(desc, MASK_FIELD_W'(mask));
               2'd1:    out_data = pack_trk_w2(desc);
               default: out_data = pack_trk_w3(desc);
            endcase
         end
         ST_HIT: begin
            if (sub == 2'd0) begin
               out_data = pack_hit_w1(last_hit, LYR_FIELD_W'(rd_layer), POS_FIELD_W'(rd_pos));
            end else begin
               out_data = pack_hit_w2(AUX_FIELD_W'(rd_aux));
            end
         end
         ST_FTR: begin
            case (sub)
               2'd0:    out_data = {EVT_FTR_TAG, 56'h0};
               2'd1:    out_data = '0;
               default: out_data = {word_cnt, CHECK_TAG};
            endcase
         end
         default: out_data = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         desc     <= '0;
         in_evt   <= 1'b0;
         sub      <= '0;
         hit_cnt  <= '0;
         hit_idx  <= '0;
         evt_seq  <= '0;
         word_cnt <= '0;
      end else begin
         if (out_fire) begin
            word_cnt <= out_last ? 32'h0 : word_cnt + 32'h1;
         end
         unique case (state)
            ST_IDLE: begin
               if (trk_fire) begin
                  desc    <= trk_in;
                  hit_cnt <= '0;
                  state   <= ST_COLLECT;
               end
            end
            ST_COLLECT: begin
               if (hit_fire) begin
                  if (hit_real) hit_cnt <= hit_cnt + CNT_W'(1);
                  if (hit_end) begin
                     sub   <= '0;
                     state <= in_evt ? ST_THDR : ST_EHDR;
                  end
               end
            end
            ST_EHDR: begin
               if (out_fire) begin
                  if (sub_end) begin
                     sub    <= '0;
                     in_evt <= 1'b1;
                     state  <= ST_THDR;
                  end else begin
                     sub <= sub + 2'd1;
                  end
               end
            end
            ST_THDR: begin
               if (out_fire) begin
                  if (sub_end) begin
                     sub     <= '0;
                     hit_idx <= '0;
                     state   <= (hit_cnt == '0) ? after_trk : ST_HIT;
                  end else begin
                     sub <= sub + 2'd1;
                  end
               end
            end
            ST_HIT: begin
               if (out_fire) begin
                  if (sub == 2'd0) begin
                     sub <= 2'd1;
                  end else begin
                     sub <= '0;
                     if (last_hit) state <= after_trk;
                     else          hit_idx <= hit_idx + CNT_W'(1);
                  end
               end
            end
            ST_FTR: begin
               if (out_fire) begin
                  if (sub_end) begin
                     sub     <= '0;
                     in_evt  <= 1'b0;
                     evt_seq <= evt_seq + 32'h1;
                     state   <= ST_IDLE;
                  end else begin
                     sub <= sub + 2'd1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R9
   hit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> (hit_cnt < CNT_W'(MAX_HITS)));
   // R7
   evt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && out_last) |=> (trk_ready && !out_valid));
   // R10
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && out_last) |=> (evt_seq == $past(evt_seq) + 32'h1));

endmodule

// File: rtl/track_record_emitter.sv
module track_record_emitter
   import emit_pkg::*;
#(
   parameter int          LAYER_W   = 4,
   parameter int          MAX_HITS  = 8,
   parameter int          POS_W     = 48,
   parameter int          AUX_W     = 32,
   parameter logic [31:0] RUN_TAG   = 32'h5EED_1234,
   parameter logic [31:0] CHECK_TAG = 32'hC0DE_0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trk_valid,
   output logic               trk_ready,
   input  logic [5:0]         trk_eta_rgn,
   input  logic [5:0]         trk_phi_rgn,
   input  logic [7:0]         trk_bin0,
   input  logic [7:0]         trk_bin1,
   input  logic [7:0]         trk_bin2,
   input  logic [7:0]         trk_bin3,
   input  logic [15:0]        trk_d0,
   input  logic [15:0]        trk_z0,
   input  logic [15:0]        trk_qpt,
   input  logic [15:0]        trk_phi,
   input  logic [15:0]        trk_eta,
   input  logic               trk_evt_end,
   input  logic               hit_valid,
   output logic               hit_ready,
   input  logic [LAYER_W-1:0] hit_layer,
   input  logic               hit_real,
   input  logic [POS_W-1:0]   hit_pos,
   input  logic [AUX_W-1:0]   hit_aux,
   input  logic               hit_end,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [63:0]        out_data,
   output logic               out_last
);

   localparam int MASK_W = (1 << LAYER_W) + 1;
   localparam int ENT_W  = LAYER_W + POS_W + AUX_W;
   localparam int RD_W   = $clog2(MAX_HITS);

   if (LAYER_W < 1 || MASK_W > MASK_FIELD_W) begin : g_bad_layer
      $error("LAYER_W must give a mask that fits the header field");
   end
   if (MAX_HITS < 2) begin : g_bad_depth
      $error("MAX_HITS must be at least 2");
   end
   if (POS_W > POS_FIELD_W || AUX_W > AUX_FIELD_W) begin : g_bad_hit
      $error("hit field widths exceed the record layout");
   end

   trk_desc_t          desc_in;
   logic [MASK_W-1:0]  mask;
   logic               mask_clr, mask_add;
   logic               buf_wr_en;
   logic [RD_W-1:0]    buf_wr_idx, buf_rd_idx;
   logic [ENT_W-1:0]   rd_ent;
   logic [LAYER_W-1:0] rd_layer;
   logic [POS_W-1:0]   rd_pos;
   logic [AUX_W-1:0]   rd_aux;

   assign desc_in = '{evt_end: trk_evt_end, eta_rgn: trk_eta_rgn, phi_rgn: trk_phi_rgn,
                      bin0: trk_bin0, bin1: trk_bin1, bin2: trk_bin2, bin3: trk_bin3,
                      d0: trk_d0, z0: trk_z0, qpt: trk_qpt, phi: trk_phi, eta: trk_eta};

   assign {rd_layer, rd_pos, rd_aux} = rd_ent;

   layer_mask_acc #(.LAYER_W(LAYER_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mask_clr),
      .add   (mask_add),
      .layer (hit_layer),
      .mask  (mask)
   );

   hit_buffer #(.DEPTH(MAX_HITS), .ENT_W(ENT_W)) u_buf (
      .clk     (clk),
      .wr_en   (buf_wr_en),
      .wr_idx  (buf_wr_idx),
      .wr_data ({hit_layer, hit_pos, hit_aux}),
      .rd_idx  (buf_rd_idx),
      .rd_data (rd_ent)
   );

   rec_sequencer #(
      .LAYER_W   (LAYER_W),
      .MAX_HITS  (MAX_HITS),
      .POS_W     (POS_W),
      .AUX_W     (AUX_W),
      .RUN_TAG   (RUN_TAG),
      .CHECK_TAG (CHECK_TAG)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .trk_valid  (trk_valid),
      .trk_ready  (trk_ready),
      .trk_in     (desc_in),
      .hit_valid  (hit_valid),
      .hit_ready  (hit_ready),
      .hit_real   (hit_real),
      .hit_end    (hit_end),
      .mask_clr   (mask_clr),
      .mask_add   (mask_add),
      .mask       (mask),
      .buf_wr_en  (buf_wr_en),
      .buf_wr_idx (buf_wr_idx),
      .buf_rd_idx (buf_rd_idx),
      .rd_layer   (rd_layer),
      .rd_pos     (rd_pos),
      .rd_aux     (rd_aux),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_last   (out_last)
   );

endmodule

// File: tb/track_record_emitter_bench.sv
`timescale 1ns/1ps
module track_record_emitter_bench;

   localparam int          LAYER_W   = 4;
   localparam int          MAX_HITS  = 8;
   localparam int          POS_W     = 48;
   localparam int          AUX_W     = 32;
   localparam logic [31:0] RUN_TAG   = 32'h5EED_1234;
   localparam logic [31:0] CHECK_TAG = 32'hC0DE_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trk_valid = 1'b0, trk_ready;
   logic [5:0] trk_eta_rgn = '0, trk_phi_rgn = '0;
   logic [7:0] trk_bin0 = '0, trk_bin1 = '0, trk_bin2 = '0, trk_bin3 = '0;
   logic [15:0] trk_d0 = '0, trk_z0 = '0, trk_qpt = '0, trk_phi = '0, trk_eta = '0;
   logic trk_evt_end = 1'b0;
   logic hit_valid = 1'b0, hit_ready;
   logic [LAYER_W-1:0] hit_layer = '0;
   logic hit_real = 1'b0;
   logic [POS_W-1:0] hit_pos = '0;
   logic [AUX_W-1:0] hit_aux = '0;
   logic hit_end = 1'b0;
   logic out_valid, out_ready = 1'b1, out_last;
   logic [63:0] out_data;

   always #2.5 clk = ~clk;

   track_record_emitter #(
      .LAYER_W(LAYER_W), .MAX_HITS(MAX_HITS), .POS_W(POS_W), .AUX_W(AUX_W),
      .RUN_TAG(RUN_TAG), .CHECK_TAG(CHECK_TAG)
   ) u_track_record_emitter (
      .clk(clk), .rst_n(rst_n),
      .trk_valid(trk_valid), .trk_ready(trk_ready),
      .trk_eta_rgn(trk_eta_rgn), .trk_phi_rgn(trk_phi_rgn),
      .trk_bin0(trk_bin0), .trk_bin1(trk_bin1), .trk_bin2(trk_bin2), .trk_bin3(trk_bin3),
      .trk_d0(trk_d0), .trk_z0(trk_z0), .trk_qpt(trk_qpt), .trk_phi(trk_phi),
      .trk_eta(trk_eta), .trk_evt_end(trk_evt_end),
      .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_layer(hit_layer),
      .hit_real(hit_real), .hit_pos(hit_pos), .hit_aux(hit_aux), .hit_end(hit_end),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit run = 1'b0;
   bit done = 1'b0;
   logic [64:0] exp_q[$];
   string tag_q[$];
   int evt_words = 0;
   int evt_seq = 0;

   task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(logic last, logic [63:0] w, string tag);
      exp_q.push_back({last, w});
      tag_q.push_back(tag);
      evt_words++;
   endtask

   // output acceptance pattern, set just after each rising edge
   initial begin
      logic [7:0] lf = 8'h5A;
      forever begin
         @(posedge clk);
         #1;
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         out_ready = run ? (lf[1:0] != 2'b00) : 1'b1;
      end
   end

   // monitor, sampled on the falling edge
   logic stalled = 1'b0;
   logic [63:0] held;
   always @(negedge clk) begin
      if (run) begin
         if (stalled) begin
            // R8 word held under back-pressure
            chk(out_valid && out_data == held, "R8", {out_valid, out_data}, {1'b1, held});
         end
         if (out_valid) begin
            // R9 no input accepted while output is pending
            chk(!trk_ready && !hit_ready, "R9", {trk_ready, hit_ready}, 65'h0);
            if (out_ready) begin
               stalled = 1'b0;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8", {out_last, out_data}, 65'h0);
               end else begin
                  logic [64:0] e;
                  string tg;
                  e = exp_q.pop_front();
                  tg = tag_q.pop_front();
                  chk({out_last, out_data} == e, tg, {out_last, out_data}, e);
               end
            end else begin
               stalled = 1'b1;
               held = out_data;
            end
         end else begin
            stalled = 1'b0;
         end
      end
   end

   task automatic send_trk(int t, bit eend);
      trk_eta_rgn = 6'((t * 3 + 1) & 63);
      trk_phi_rgn = 6'((t * 11) & 63);
      trk_bin0 = 8'(t + 1); trk_bin1 = 8'(t + 2); trk_bin2 = 8'(t + 3); trk_bin3 = 8'(t + 4);
      trk_d0 = 16'(16'h1000 + t); trk_z0 = 16'(16'h2000 + t * 3);
      trk_qpt = 16'(16'h8000 | t); trk_phi = 16'(16'h4000 + t); trk_eta = 16'(16'hF000 - t);
      trk_evt_end = eend;
      trk_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (trk_ready) break;
      end
      @(posedge clk);
      #1 trk_valid = 1'b0;
   endtask

   task automatic send_hit(int layer, bit real_h, logic [47:0] pos, logic [31:0] aux, bit hend, int gap);
      repeat (gap) @(posedge clk);
      #1;
      hit_layer = LAYER_W'(layer); hit_real = real_h; hit_pos = pos; hit_aux = aux; hit_end = hend;
      hit_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (hit_ready) break;
      end
      @(posedge clk);
      #1 hit_valid = 1'b0;
   endtask

   function automatic int lyr_of(int t, int k);
      return (t * 5 + k * 7) % 16;
   endfunction

   initial begin
      int t = 0;
      int trk_in_evt = 0;
      repeat (3) @(posedge clk);
      #1;
      // reset state: R9 track input open, hit input closed; R8 nothing pending
      chk(trk_ready == 1'b1, "R9", 65'(trk_ready), 65'd1);
      chk(hit_ready == 1'b0, "R9", 65'(hit_ready), 65'd0);
      chk(out_valid == 1'b0, "R8", 65'(out_valid), 65'd0);
      rst_n = 1'b1;
      run = 1'b1;
      for (int n = 1; n <= 4; n++) begin
         for (int pat = 0; pat < (1 << n); pat++) begin
            bit eend;
            logic [63:0] m;
            int nreal;
            int lastk;
            eend = (trk_in_evt == 3) || (n == 4 && pat == 15);
            if (trk_in_evt == 0) begin
               evt_words = 0;
               push(1'b0, {8'hB5, 24'h0, 32'(evt_seq)}, "R1");
               push(1'b0, {RUN_TAG, 32'h0}, "R1");
               push(1'b0, 64'h0, "R1");
            end
            // R3 mask from all hits, real or fake
            m = 64'h0;
            nreal = 0;
            lastk = -1;
            for (int k = 0; k < n; k++) begin
               m = m | (64'd2 << lyr_of(t, k));
               if (pat[k]) begin nreal++; lastk = k; end
            end
            push(1'b0, (64'hEE << 56) | (64'((t * 3 + 1) & 63) << 48) | (64'((t * 11) & 63) << 42)
                       | (64'((t + 1) & 255) << 34) | (64'((t + 2) & 255) << 26) | m, "R2 R3");
            push(1'b0, (64'((t + 3) & 255) << 56) | (64'(16'h1000 + t) << 40)
                       | (64'(16'h2000 + t * 3) << 24), "R4");
            push(1'b0, (64'(16'h8000 | t) << 48) | (64'(16'h4000 + t) << 32)
                       | (64'(16'hF000 - t) << 16) | (64'((t + 4) & 255) << 8), "R4");
            for (int k = 0; k < n; k++) begin
               if (pat[k]) begin
                  // R5 real hit words; R6 last flag on final real hit
                  push(1'b0, ((k == lastk) ? 64'h8000_0000_0000_0000 : 64'h0)
                             | (64'(lyr_of(t, k)) << 56) | 64'(48'hA000_0000_0000 | 48'(t * 256 + k)),
                       "R5 R6");
                  push(1'b0, 64'(32'h5A00_0000 | 32'(t * 16 + k)), "R5");
               end
            end
            if (eend) begin
               push(1'b0, 64'hD7 << 56, "R7");
               push(1'b0, 64'h0, "R7");
               push(1'b1, (64'(evt_words) << 32) | 64'(CHECK_TAG), "R7 R10");
               evt_seq++;
               trk_in_evt = 0;
            end else begin
               trk_in_evt++;
            end
            send_trk(t, eend);
            for (int k = 0; k < n; k++) begin
               send_hit(lyr_of(t, k), pat[k], 48'hA000_0000_0000 | 48'(t * 256 + k),
                        32'h5A00_0000 | 32'(t * 16 + k), k == n - 1, (t + k) % 3);
            end
            t++;
         end
      end
      while (exp_q.size() != 0) @(posedge clk);
      repeat (10) @(posedge clk);
      @(negedge clk);
      // R8 no extra words after the expected stream
      chk(out_valid == 1'b0, "R8", 65'(out_valid), 65'd0);
      // R9 back to idle
      chk(trk_ready == 1'b1, "R9", 65'(trk_ready), 65'd1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R8 actual=%0d expected=0 words outstanding", exp_q.size());
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule